// File: doc/BRIEF.md
# Queue Completion Context Access Engine

This block gives software indirect access to a table of 128-bit completion-queue contexts, one entry per queue, held in an internal single-port RAM. Software never addresses the table directly. It first stages a context value in four 32-bit data registers, then writes a command register that names a queue, picks an operation (clear, write or read) and sets a start bit. The engine then runs the access. For a read it returns the entry through the same four data registers. It reports an out-of-range queue number through a status flag and drops the start/busy bit when the work is finished.

The engine does not interpret the context. The data registers are laid out so that software can place the usual fields: consumer index in bits [15:0], producer index in [31:16], queue size in [47:32], a valid bit at [63], the 4K-aligned ring base in [115:64], the interrupt vector in [126:116] and the interrupt enable at [127].

The register port is a request/response pair. A request is taken in every cycle where `req_valid` is high, so the engine never applies back-pressure. Every read request gets exactly one response: `rsp_valid` is high for one cycle, in the cycle after the request, with the read data. The response cannot be stalled, so the requester must always be ready to accept it.

Top module: `qctx_access_engine`

## Requirements
- R1: After reset, all four data registers and the command register read as zero.
- R2: A read request gets `rsp_valid` for one cycle in the next cycle. Register map: data word k sits at 0x6000+4k, and word k carries context bits [32k+31:32k]. The command register sits at 0x6010.
- R3: A WRITE (op code 1) stores the four data words into the selected queue's entry. A later READ (op code 2) of that queue returns them in the data registers in the same word order.
- R4: A CLEAR (op code 0) sets every bit of the selected entry to zero.
- R5: A queue number at or above NUM_QUEUES sets command bit 1 (invalid flag). In that case the context RAM and the data registers are left unchanged, and busy still clears.
- R6: Op code 3 changes no entry, no data register and no invalid flag, and busy still clears.
- R7: Command bit 0 reads 1 from the cycle after a start write until the operation ends. It stays 1 for one cycle for CLEAR, WRITE, op code 3 and invalid queues, and for two cycles for a valid READ.
- R8: While busy is 1, writes to the command register and to the data registers are ignored.
- R9: The invalid flag is cleared when the next operation starts.
- R10: The command register holds the queue number in bits [17:7] and the op code in bits [6:5]. A write with bit 0 clear updates these fields without starting an operation. Bits [31:18], [4:2] and the invalid flag cannot be written, and the unused bits read as zero.
- R11: Reads of any address outside the five registers return zero, and writes to them have no effect.
- R12: Entries are independent of each other, and queue NUM_QUEUES-1 is a valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present, always accepted |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata | output | DATA_W | Read response data |

## Verification
The bench builds the engine with NUM_QUEUES set to 12, which is not a power of two. With that value, queue 11 is the last valid entry and queue 12 is the first invalid one. Queue number 19 then maps to the same RAM address bits as entry 3. An invalid write to queue 19 would therefore corrupt a known entry if the range check were missing. The default 11-bit queue field also lets the bench probe numbers far above the table.

// File: rtl/qctx_pkg.sv
`timescale 1ns/1ps
package qctx_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } ctx_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_EXEC   = 2'd1,
    SQ_RDWAIT = 2'd2
  } seq_state_e;

  // command word bit positions
  localparam int CMD_START_BIT = 0;
  localparam int CMD_INV_BIT   = 1;
  localparam int CMD_OP_LSB    = 5;
  localparam int CMD_QID_LSB   = 7;

endpackage

// File: rtl/qctx_regfile.sv
`timescale 1ns/1ps
module qctx_regfile
  import qctx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NUM_WORDS = 4,
  parameter int QID_W = 11,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h6000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata,
  input  logic                        seq_done,
  input  logic                        seq_inv,
  input  logic                        seq_load,
  input  logic [DATA_W*NUM_WORDS-1:0] load_data,
  output logic                        start,
  output logic                        busy,
  output logic [QID_W-1:0]            qid,
  output ctx_op_e                     op,
  output logic [DATA_W*NUM_WORDS-1:0] ctx_data
);

  localparam logic [ADDR_W-1:0] CMD_ADDR = BASE_ADDR + ADDR_W'(4 * NUM_WORDS);

  logic [DATA_W-1:0]    data_q [NUM_WORDS];
  logic [NUM_WORDS-1:0] hit_data;
  logic                 hit_cmd;
  logic                 wr_ok;
  logic                 busy_q;
  logic                 inv_q;
  logic [QID_W-1:0]     qid_q;
  ctx_op_e              op_q;
  logic [DATA_W-1:0]    cmd_word;
  logic [DATA_W-1:0]    rd_word;

  assign hit_cmd = (req_addr == CMD_ADDR);
  assign wr_ok   = req_valid && req_write && !busy_q;
  assign start   = wr_ok && hit_cmd && req_wdata[CMD_START_BIT];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WORDS; gi++) begin : g_word
      localparam logic [ADDR_W-1:0] WORD_ADDR = BASE_ADDR + ADDR_W'(4 * gi);
      assign hit_data[gi] = (req_addr == WORD_ADDR);
      assign ctx_data[gi*DATA_W +: DATA_W] = data_q[gi];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          data_q[gi] <= '0;
        end else if (seq_load) begin
          data_q[gi] <= load_data[gi*DATA_W +: DATA_W];
        end else if (wr_ok && hit_data[gi]) begin
          data_q[gi] <= req_wdata;
        end
      end
    end
  endgenerate

  // command fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qid_q <= '0;
      op_q  <= OP_CLEAR;
    end else if (wr_ok && hit_cmd) begin
      qid_q <= req_wdata[CMD_QID_LSB +: QID_W];
      op_q  <= ctx_op_e'(req_wdata[CMD_OP_LSB +: 2]);
    end
  end

  // start/busy and invalid flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
      end else if (seq_done) begin
        busy_q <= 1'b0;
      end
      if (start) begin
        inv_q <= 1'b0;
      end else if (seq_inv) begin
        inv_q <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_QID_LSB +: QID_W] = qid_q;
    cmd_word[CMD_OP_LSB +: 2]      = op_q;
    cmd_word[CMD_INV_BIT]          = inv_q;
    cmd_word[CMD_START_BIT]        = busy_q;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (hit_data[i]) rd_word = data_q[i];
    end
    if (hit_cmd) rd_word = cmd_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        rsp_rdata <= rd_word;
      end
    end
  end

  assign busy = busy_q;
  assign qid  = qid_q;
  assign op   = op_q;

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q); // R7

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R2

  AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(qid_q) && $stable(op_q))); // R8

  AST_LOAD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_load |-> busy_q); // R3

endmodule

// File: rtl/qctx_seq.sv
`timescale 1ns/1ps
module qctx_seq
  import qctx_pkg::*;
#(
  parameter int NUM_QUEUES = 16,
  parameter int QID_W = 11,
  parameter int CTX_W = 128,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [QID_W-1:0] qid,
  input  ctx_op_e          op,
  input  logic [CTX_W-1:0] ctx_data,
  output logic             mem_we,
  output logic             mem_re,
  output logic [AW-1:0]    mem_addr,
  output logic [CTX_W-1:0] mem_wdata,
  output logic             done,
  output logic             inv,
  output logic             load
);

  seq_state_e st_q, st_d;
  logic       qid_ok;

  assign qid_ok   = (32'(qid) < 32'(NUM_QUEUES));
  assign mem_addr = qid[AW-1:0];

  always_comb begin
    st_d      = st_q;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = ctx_data;
    done      = 1'b0;
    inv       = 1'b0;
    load      = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start) st_d = SQ_EXEC;
      end
      SQ_EXEC: begin
        st_d = SQ_IDLE;
        if (!qid_ok) begin
          inv  = 1'b1;
          done = 1'b1;
        end else begin
          case (op)
            OP_CLEAR: begin
              mem_we    = 1'b1;
              mem_wdata = '0;
              done      = 1'b1;
            end
            OP_WRITE: begin
              mem_we = 1'b1;
              done   = 1'b1;
            end
            OP_READ: begin
              mem_re = 1'b1;
              st_d   = SQ_RDWAIT;
            end
            default: done = 1'b1;
          endcase
        end
      end
      SQ_RDWAIT: begin
        load = 1'b1;
        done = 1'b1;
        st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  AST_RDWAIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RDWAIT) |=> (st_q == SQ_IDLE)); // R7

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == SQ_IDLE)); // R8

  AST_EXEC_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st_q == SQ_EXEC)); // R7

endmodule

// File: rtl/qctx_ram.sv
`timescale 1ns/1ps
module qctx_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 128,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  AST_RAM_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (we || re) |-> (32'(addr) < 32'(DEPTH))); // R5

endmodule

// File: rtl/qctx_access_engine.sv
`timescale 1ns/1ps
module qctx_access_engine
  import qctx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NUM_WORDS = 4,
  parameter int QID_W = 11,
  parameter int NUM_QUEUES = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int CTX_W = DATA_W * NUM_WORDS;
  localparam int AW    = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;

  logic             start, busy, seq_done, seq_inv, seq_load;
  logic [QID_W-1:0] qid;
  ctx_op_e          op;
  logic [CTX_W-1:0] ctx_data, mem_wdata, mem_rdata;
  logic             mem_we, mem_re;
  logic [AW-1:0]    mem_addr;

  qctx_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS),
    .QID_W(QID_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .seq_done(seq_done), .seq_inv(seq_inv), .seq_load(seq_load),
    .load_data(mem_rdata),
    .start(start), .busy(busy), .qid(qid), .op(op), .ctx_data(ctx_data)
  );

  qctx_seq #(
    .NUM_QUEUES(NUM_QUEUES), .QID_W(QID_W), .CTX_W(CTX_W), .AW(AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .qid(qid), .op(op),
    .ctx_data(ctx_data),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata),
    .done(seq_done), .inv(seq_inv), .load(seq_load)
  );

  qctx_ram #(
    .DEPTH(NUM_QUEUES), .WIDTH(CTX_W), .AW(AW)
  ) u_ram (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .re(mem_re),
    .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy); // R8

  AST_WE_VALID_QID: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (32'(qid) < 32'(NUM_QUEUES))); // R5

  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy); // R7

endmodule

// File: tb/qctx_access_engine_test.sv
`timescale 1ns/1ps
module qctx_access_engine_test;

  localparam int NQ = 12;
  localparam logic [15:0] D0  = 16'h6000;
  localparam logic [15:0] CMD = 16'h6010;
  localparam logic [1:0] OPC = 2'd0, OPW = 2'd1, OPR = 2'd2, OPX = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  qctx_access_engine #(.NUM_QUEUES(NQ)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] cmdw(input int q, input logic [1:0] o, input bit s);
    return (32'(q) << 7) | (32'(o) << 5) | 32'(s);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
    end
  endtask

  task automatic load_ctx(input logic [127:0] v);
    for (int k = 0; k < 4; k++) wr(D0 + 16'(4*k), v[32*k +: 32]);
  endtask

  task automatic chk_ctx(input logic [127:0] v, input string t);
    for (int k = 0; k < 4; k++) rd_chk(D0 + 16'(4*k), v[32*k +: 32], t);
  endtask

  task automatic run(input int q, input logic [1:0] o);
    wr(CMD, cmdw(q, o, 1'b1));
    idle(3);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected response: actual=%h expected=none", rsp_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rsp_rdata !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, rsp_rdata, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      report();
    end
  end

  localparam logic [127:0] PA = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  localparam logic [127:0] PB = 128'h8000_0001_dead_beef_8000_0040_0000_0005;
  localparam logic [127:0] PC = 128'h5555_aaaa_3333_cccc_0f0f_f0f0_1111_eeee;
  localparam logic [127:0] PD = 128'hcafe_f00d_1234_5678_9abc_def0_0bad_c0de;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values
    for (int k = 0; k < 4; k++) rd_chk(D0 + 16'(4*k), 32'h0, "R1 data reset");
    rd_chk(CMD, 32'h0, "R1 cmd reset");

    // R11: unmapped addresses
    wr(16'h6014, 32'hffff_ffff);
    rd_chk(16'h6014, 32'h0, "R11 unmapped 0x6014");
    rd_chk(16'h5ffc, 32'h0, "R11 unmapped 0x5ffc");

    // R10: field write without start, reserved and RO bits ignored
    wr(CMD, 32'hfffc_001e | cmdw(5, OPR, 1'b0));
    rd_chk(CMD, cmdw(5, OPR, 1'b0), "R10 fields only");
    idle(2);
    rd_chk(CMD, cmdw(5, OPR, 1'b0), "R10 no start");

    run(5, OPC);

    // R3/R7: write entry 3, busy for one cycle
    load_ctx(PA);
    wr(CMD, cmdw(3, OPW, 1'b1));
    rd_chk(CMD, cmdw(3, OPW, 1'b1), "R7 write busy");
    idle(2);
    rd_chk(CMD, cmdw(3, OPW, 1'b0), "R7 write done");

    // R12: last valid queue
    load_ctx(PB);
    run(NQ - 1, OPW);

    // R3/R7: read entry 3, busy for two cycles
    load_ctx(PC);
    wr(CMD, cmdw(3, OPR, 1'b1));
    rd_chk(CMD, cmdw(3, OPR, 1'b1), "R7 read busy c1");
    rd_chk(CMD, cmdw(3, OPR, 1'b1), "R7 read busy c2");
    rd_chk(CMD, cmdw(3, OPR, 1'b0), "R7 read done");
    chk_ctx(PA, "R3 readback order");

    run(NQ - 1, OPR);
    chk_ctx(PB, "R12 last queue");

    // R5: invalid qid 12 on read
    run(NQ, OPR);
    rd_chk(CMD, cmdw(NQ, OPR, 1'b0) | 32'h2, "R5 invalid flag");
    chk_ctx(PB, "R5 data untouched");

    // R5: invalid qid 19 aliases entry 3 in the address bits
    load_ctx(PD);
    run(19, OPW);
    rd_chk(CMD, cmdw(19, OPW, 1'b0) | 32'h2, "R5 invalid write flag");
    run(3, OPR);
    rd_chk(CMD, cmdw(3, OPR, 1'b0), "R9 flag cleared on start");
    chk_ctx(PA, "R5 entry untouched");

    // R6: reserved op code
    load_ctx(PD);
    wr(CMD, cmdw(3, OPX, 1'b1));
    rd_chk(CMD, cmdw(3, OPX, 1'b1), "R6 reserved busy");
    idle(2);
    rd_chk(CMD, cmdw(3, OPX, 1'b0), "R6 reserved done no flag");
    rd_chk(D0, PD[31:0], "R6 data unchanged");
    run(3, OPR);
    chk_ctx(PA, "R6 entry unchanged");

    // R4: clear
    run(3, OPC);
    run(3, OPR);
    chk_ctx(128'h0, "R4 cleared");
    run(NQ - 1, OPR);
    chk_ctx(PB, "R12 neighbour kept");

    // R8: writes during busy ignored
    wr(CMD, cmdw(NQ - 1, OPR, 1'b1));
    wr(CMD, cmdw(5, OPW, 1'b1));
    wr(D0, 32'hdead_beef);
    idle(3);
    rd_chk(CMD, cmdw(NQ - 1, OPR, 1'b0), "R8 cmd write ignored");
    rd_chk(D0, PB[31:0], "R8 data write ignored");
    run(5, OPR);
    chk_ctx(128'h0, "R8 entry 5 untouched");
    wr(CMD, cmdw(5, OPC, 1'b1));
    wr(D0 + 16'd4, 32'h1234_5678);
    idle(3);
    rd_chk(D0 + 16'd4, 32'h0, "R8 data write during clear");

    idle(4);
    finished = 1'b1;
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing responses: actual=%0d expected=0", exp_q.size());
    end
    report();
  end

endmodule